// File: doc/BRIEF.md
# Dynamic Multiply-Accumulate Element

This block is one arithmetic element of a configurable DSP slice. It multiplies two operands of equal width and adds the product to a running accumulator, or subtracts it. Two control inputs can change on any cycle. One chooses whether the operands are two's complement or unsigned. The other chooses whether the product is added or subtracted. A load strobe starts a new sum: the accumulator takes the current product and the old total is dropped.

Each operand register has its own source select. It loads either from the element's own operand port or from a shift-in port. The shift-in port is meant to be wired to the shift-out port of the previous identical element, so operand values can ripple along a row of elements. The input, pipeline and output register stages are each switched in or out by a parameter. A stage that is switched out becomes a plain wire. The mode controls are registered next to the data at every stage, so each product is accumulated under the mode it was sampled with.

The reset is asynchronous and active low. Its release is expected to be synchronised to the clock before it reaches the block.

Top module: `mac_element`

## Requirements
- R1: With `acc_load` low and `sub_mode` low, an accumulate step gives acc + A*B. The accumulator is 2*OPW+GUARD bits wide (GUARD defaults to 16) and wraps modulo 2^(2*OPW+GUARD).
- R2: When `sgn_mode` is 1 for a cycle, both operands sampled in that cycle are two's complement. When it is 0, both are unsigned.
- R3: When `sub_mode` is 1 for a cycle, the product of that cycle's operands is subtracted from the accumulator instead of added.
- R4: When `acc_load` is 1 for a cycle, that cycle's product replaces the accumulator contents and the overflow flag for that step is 0.
- R5: `a_shift_sel` and `b_shift_sel` each choose, per cycle, the source of their operand: 1 takes `a_shin`/`b_shin`, 0 takes `a_in`/`b_in`.
- R6: `a_shout` and `b_shout` carry the contents of the operand registers. When the input stage is disabled, they carry the selected operand directly.
- R7: Operands and controls sampled at an enabled clock edge j show up at `acc_out`/`ovf` after enabled edge j+IN_EN+PIPE_EN+OUT_EN. Each operand set uses the controls sampled with it.
- R8: `ovf` is 1 for the step result in these cases:
  - unsigned mode: the add carries out of the accumulator, or the subtract borrows;
  - signed mode: the two's-complement result leaves the range of the accumulator.
- R9: While `ce` is low, every register holds. `acc_out`, `ovf` and (with the input stage on) the shift-out ports stay unchanged, whatever the other inputs do.
- R10: While `rst_n` is low, `acc_out`, `ovf` and the shift-out ports are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for every register stage |
| a_in | input | OPW | Parallel operand A |
| b_in | input | OPW | Parallel operand B |
| a_shift_sel | input | 1 | 1: operand A is taken from a_shin |
| b_shift_sel | input | 1 | 1: operand B is taken from b_shin |
| a_shin | input | OPW | Operand A from the previous element |
| b_shin | input | OPW | Operand B from the previous element |
| sgn_mode | input | 1 | 1: signed operands, 0: unsigned |
| sub_mode | input | 1 | 1: subtract product, 0: add |
| acc_load | input | 1 | 1: accumulator takes the product |
| a_shout | output | OPW | Operand A register contents |
| b_shout | output | OPW | Operand B register contents |
| acc_out | output | 2*OPW+GUARD | Accumulator value |
| ovf | output | 1 | Overflow of the last accumulate step |

## Verification
The bench builds two copies of the block, both with OPW=4 and GUARD=2, which gives a 10-bit accumulator:
- `dut` has every register stage enabled.
- `dut_comb` has every register stage disabled.

The small operand width lets the bench sweep all 256 operand pairs under all four sign and direction combinations, and a load strobe recurs during the sweep. The narrow guard means carries, borrows and signed overflow happen often. Running both copies checks the three-stage latency and the fully bypassed path against the same arithmetic model.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Per-operation controls that travel with the operands.
  typedef struct packed {
    logic sgn;   // operands two's complement
    logic sub;   // subtract product
    logic load;  // replace accumulator with product
  } mac_ctl_t;

  localparam int unsigned CTLW = $bits(mac_ctl_t);
endpackage

// File: rtl/mac_pipe_reg.sv
// Optional pipeline register: a flop with clock enable, or a wire.
module mac_pipe_reg #(
  parameter int unsigned W  = 1,
  parameter bit          EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r, q_nxt;

      always_comb begin
        q_nxt = ce ? d : q_r;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q = q_r;
    end else begin : g_wire
      logic unused_bypass;
      assign unused_bypass = ^{clk, rst_n, ce};
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mac_opnd_in.sv
// Operand input stage: parallel/shift source select, then optional register.
module mac_opnd_in #(
  parameter int unsigned OPW = 9,
  parameter bit          EN  = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic [OPW-1:0] par_d,
  input  logic [OPW-1:0] shift_d,
  input  logic           use_shift,
  output logic [OPW-1:0] q
);
  logic [OPW-1:0] src;

  always_comb begin
    src = use_shift ? shift_d : par_d;
  end

  mac_pipe_reg #(.W(OPW), .EN(EN)) u_reg (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(src), .q(q)
  );
endmodule

// File: rtl/mac_mult.sv
// Signed/unsigned multiplier: one extra bit per operand makes both modes signed.
module mac_mult #(
  parameter int unsigned OPW = 9,
  localparam int unsigned PW = 2 * OPW + 2
) (
  input  logic           [OPW-1:0] a,
  input  logic           [OPW-1:0] b,
  input  logic                     sgn,
  output logic signed    [PW-1:0]  prod
);
  logic signed [OPW:0]   a_x, b_x;
  logic signed [PW-1:0]  a_w, b_w;

  always_comb begin
    a_x  = {sgn & a[OPW-1], a};
    b_x  = {sgn & b[OPW-1], b};
    a_w  = PW'(a_x);
    b_w  = PW'(b_x);
    prod = a_w * b_w;
  end
endmodule

// File: rtl/mac_accum.sv
// Accumulator with mode-dependent overflow detection.
module mac_accum
  import mac_pkg::*;
#(
  parameter int unsigned ACCW = 34
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic [ACCW-1:0] p,
  input  mac_ctl_t        ctl,
  output logic [ACCW-1:0] acc_q,
  output logic            ovf_q
);
  localparam int unsigned MSB = ACCW - 1;

  logic [ACCW:0]   sum_u, dif_u;
  logic [ACCW-1:0] res, acc_nxt;
  logic            step_ovf, ovf_nxt;

  always_comb begin
    sum_u = {1'b0, acc_q} + {1'b0, p};
    dif_u = {1'b0, acc_q} - {1'b0, p};
    res   = ctl.sub ? dif_u[MSB:0] : sum_u[MSB:0];
    if (ctl.sgn) begin
      if (ctl.sub) step_ovf = (acc_q[MSB] != p[MSB]) && (res[MSB] != acc_q[MSB]);
      else         step_ovf = (acc_q[MSB] == p[MSB]) && (res[MSB] != acc_q[MSB]);
    end else begin
      step_ovf = ctl.sub ? dif_u[ACCW] : sum_u[ACCW];
    end

    acc_nxt = acc_q;
    ovf_nxt = ovf_q;
    if (ce) begin
      acc_nxt = ctl.load ? p : res;
      ovf_nxt = step_ovf & ~ctl.load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_nxt;
      ovf_q <= ovf_nxt;
    end
  end
endmodule

// File: rtl/mac_element.sv
module mac_element
  import mac_pkg::*;
#(
  parameter int unsigned OPW     = 9,
  parameter int unsigned GUARD   = 16,
  parameter bit          IN_EN   = 1'b1,
  parameter bit          PIPE_EN = 1'b1,
  parameter bit          OUT_EN  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic [OPW-1:0]           a_in,
  input  logic [OPW-1:0]           b_in,
  input  logic                     a_shift_sel,
  input  logic                     b_shift_sel,
  input  logic [OPW-1:0]           a_shin,
  input  logic [OPW-1:0]           b_shin,
  input  logic                     sgn_mode,
  input  logic                     sub_mode,
  input  logic                     acc_load,
  output logic [OPW-1:0]           a_shout,
  output logic [OPW-1:0]           b_shout,
  output logic [2*OPW+GUARD-1:0]   acc_out,
  output logic                     ovf
);
  localparam int unsigned PW   = 2 * OPW + 2;
  localparam int unsigned ACCW = 2 * OPW + GUARD;

  mac_ctl_t        ctl_in, ctl_s1, acc_ctl;
  logic [OPW-1:0]  a_s1, b_s1;
  logic signed [PW-1:0] prod_s1;
  logic [PW-1:0]   prod_s2;
  logic [PW+CTLW-1:0] pipe_d, pipe_q;
  logic [ACCW-1:0] acc_p, acc_q;
  logic            ovf_q;
  logic [ACCW:0]   out_q;

  always_comb begin
    ctl_in.sgn  = sgn_mode;
    ctl_in.sub  = sub_mode;
    ctl_in.load = acc_load;
  end

  // Input stage: operands and their controls
  mac_opnd_in #(.OPW(OPW), .EN(IN_EN)) u_a_in (
    .clk(clk), .rst_n(rst_n), .ce(ce), .par_d(a_in), .shift_d(a_shin),
    .use_shift(a_shift_sel), .q(a_s1)
  );

  mac_opnd_in #(.OPW(OPW), .EN(IN_EN)) u_b_in (
    .clk(clk), .rst_n(rst_n), .ce(ce), .par_d(b_in), .shift_d(b_shin),
    .use_shift(b_shift_sel), .q(b_s1)
  );

  mac_pipe_reg #(.W(CTLW), .EN(IN_EN)) u_ctl_in (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(ctl_in), .q(ctl_s1)
  );

  assign a_shout = a_s1;
  assign b_shout = b_s1;

  // Multiplier
  mac_mult #(.OPW(OPW)) u_mult (
    .a(a_s1), .b(b_s1), .sgn(ctl_s1.sgn), .prod(prod_s1)
  );

  // Pipeline stage: product with its controls
  assign pipe_d = {prod_s1, ctl_s1};

  mac_pipe_reg #(.W(PW + CTLW), .EN(PIPE_EN)) u_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(pipe_d), .q(pipe_q)
  );

  assign prod_s2 = pipe_q[PW+CTLW-1:CTLW];
  assign acc_ctl = mac_ctl_t'(pipe_q[CTLW-1:0]);
  assign acc_p   = {{(ACCW-PW){prod_s2[PW-1]}}, prod_s2};

  // Accumulator
  mac_accum #(.ACCW(ACCW)) u_acc (
    .clk(clk), .rst_n(rst_n), .ce(ce), .p(acc_p), .ctl(acc_ctl),
    .acc_q(acc_q), .ovf_q(ovf_q)
  );

  // Output stage
  mac_pipe_reg #(.W(ACCW + 1), .EN(OUT_EN)) u_out (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d({ovf_q, acc_q}), .q(out_q)
  );

  assign ovf     = out_q[ACCW];
  assign acc_out = out_q[ACCW-1:0];
endmodule

// File: rtl/mac_element_chk.sv
module mac_element_chk #(
  parameter int unsigned OPW   = 9,
  parameter int unsigned ACCW  = 34,
  parameter bit          IN_EN = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce,
  input logic [OPW-1:0]  a_shout,
  input logic [OPW-1:0]  b_shout,
  input logic [ACCW-1:0] acc_out,
  input logic            ovf,
  input logic [ACCW-1:0] acc_q,
  input logic            ovf_q,
  input logic [ACCW-1:0] acc_p,
  input logic [2:0]      acc_ctl
);
  // acc_ctl bit order: [2]=signed, [1]=subtract, [0]=load
  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(acc_out) && $stable(ovf)); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc_out == '0) && !ovf); // R10

  AST_LOAD_TAKES_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    ce && acc_ctl[0] |=> acc_q == $past(acc_p)); // R4

  AST_LOAD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ce && acc_ctl[0] |=> !ovf_q); // R4

  AST_UNSIGNED_ADD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    ce && acc_ctl == 3'b000 |=> ovf_q || (acc_q >= $past(acc_q))); // R8

  AST_UNSIGNED_SUB_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    ce && acc_ctl == 3'b010 |=> ovf_q || (acc_q <= $past(acc_q))); // R3

  generate
    if (IN_EN) begin : g_shout
      AST_SHOUT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(a_shout) && $stable(b_shout)); // R6
    end
  endgenerate
endmodule

bind mac_element mac_element_chk #(
  .OPW(OPW), .ACCW(ACCW), .IN_EN(IN_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .a_shout(a_shout), .b_shout(b_shout),
  .acc_out(acc_out), .ovf(ovf), .acc_q(acc_q), .ovf_q(ovf_q),
  .acc_p(acc_p), .acc_ctl(acc_ctl)
);

// File: tb/tb_mac_element.sv
`timescale 1ns/1ps
module tb_mac_element;
  localparam int OPW  = 4;
  localparam int ACCW = 10;
  localparam int LAT  = 3;
  localparam int MAXOPS = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic [OPW-1:0] a_in = '0, b_in = '0, a_shin = '0, b_shin = '0;
  logic a_shift_sel = 1'b0, b_shift_sel = 1'b0;
  logic sgn_mode = 1'b0, sub_mode = 1'b0, acc_load = 1'b0;
  logic [OPW-1:0]  a_sh_p, b_sh_p, a_sh_c, b_sh_c;
  logic [ACCW-1:0] acc_p, acc_c;
  logic            ovf_p, ovf_c;

  always #5 clk = ~clk;

  mac_element #(.OPW(OPW), .GUARD(2), .IN_EN(1'b1), .PIPE_EN(1'b1), .OUT_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .a_in(a_in), .b_in(b_in),
    .a_shift_sel(a_shift_sel), .b_shift_sel(b_shift_sel),
    .a_shin(a_shin), .b_shin(b_shin), .sgn_mode(sgn_mode), .sub_mode(sub_mode),
    .acc_load(acc_load), .a_shout(a_sh_p), .b_shout(b_sh_p),
    .acc_out(acc_p), .ovf(ovf_p)
  );

  mac_element #(.OPW(OPW), .GUARD(2), .IN_EN(1'b0), .PIPE_EN(1'b0), .OUT_EN(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .ce(ce), .a_in(a_in), .b_in(b_in),
    .a_shift_sel(a_shift_sel), .b_shift_sel(b_shift_sel),
    .a_shin(a_shin), .b_shin(b_shin), .sgn_mode(sgn_mode), .sub_mode(sub_mode),
    .acc_load(acc_load), .a_shout(a_sh_c), .b_shout(b_sh_c),
    .acc_out(acc_c), .ovf(ovf_c)
  );

  int errors = 0;
  int checks = 0;
  int n_ops  = 0;
  bit done   = 1'b0;
  bit last_en = 1'b0;
  int m_acc  = 0;
  int exp_acc [MAXOPS];
  bit exp_ovf [MAXOPS];
  bit op_ld   [MAXOPS];
  int eff_a   [MAXOPS];
  int eff_b   [MAXOPS];

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (op %0d)", tag, act, expv, n_ops);
    end
  endtask

  // Compare both copies against the model after the last clock edge.
  task automatic check_outputs();
    int ip, ic;
    string frz;
    frz = last_en ? "" : " R9 hold";
    ip = n_ops - 1 - LAT;
    ic = n_ops - 1;
    if (ip >= 0) begin
      chk(op_ld[ip] ? {"R4 load pipelined", frz} : {"R1 R2 R3 R5 R7 acc pipelined", frz},
          int'(acc_p), exp_acc[ip]);
      chk({"R8 ovf pipelined", frz}, int'(ovf_p), int'(exp_ovf[ip]));
    end else begin
      chk("R7 R10 pipeline still empty acc", int'(acc_p), 0);
      chk("R7 R10 pipeline still empty ovf", int'(ovf_p), 0);
    end
    if (ic >= 0) begin
      chk(op_ld[ic] ? {"R4 load bypassed", frz} : {"R1 R2 R3 R5 R7 acc bypassed", frz},
          int'(acc_c), exp_acc[ic]);
      chk({"R8 ovf bypassed", frz}, int'(ovf_c), int'(exp_ovf[ic]));
      chk({"R6 a_shout", frz}, int'(a_sh_p), eff_a[ic]);
      chk({"R6 b_shout", frz}, int'(b_sh_p), eff_b[ic]);
    end
  endtask

  task automatic do_op(input int a, input int b, input int ash, input int bsh,
                       input bit asel, input bit bsel, input bit sg, input bit sb,
                       input bit ld, input bit en);
    int ea, eb, sa, sbv, prod, av, r;
    @(negedge clk);
    check_outputs();
    a_in = OPW'(a); b_in = OPW'(b); a_shin = OPW'(ash); b_shin = OPW'(bsh);
    a_shift_sel = asel; b_shift_sel = bsel;
    sgn_mode = sg; sub_mode = sb; acc_load = ld; ce = en;
    if (en) begin
      ea = asel ? (ash & 15) : (a & 15);
      eb = bsel ? (bsh & 15) : (b & 15);
      sa  = (sg && ea >= 8) ? ea - 16 : ea;
      sbv = (sg && eb >= 8) ? eb - 16 : eb;
      prod = sa * sbv;
      eff_a[n_ops] = ea;
      eff_b[n_ops] = eb;
      op_ld[n_ops] = ld;
      if (ld) begin
        m_acc = prod & 1023;
        exp_ovf[n_ops] = 1'b0;
      end else begin
        av = (sg && m_acc >= 512) ? m_acc - 1024 : m_acc;
        r  = sb ? av - prod : av + prod;
        if (sg) exp_ovf[n_ops] = (r < -512) || (r > 511);
        else    exp_ovf[n_ops] = (r < 0) || (r > 1023);
        m_acc = r & 1023;
      end
      exp_acc[n_ops] = m_acc;
      n_ops++;
    end
    last_en = en;
    @(posedge clk);
  endtask

  initial begin
    // Reset state (R10)
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset acc pipelined", int'(acc_p), 0);
    chk("R10 reset ovf pipelined", int'(ovf_p), 0);
    chk("R10 reset acc bypassed", int'(acc_c), 0);
    chk("R10 reset a_shout", int'(a_sh_p), 0);
    chk("R10 reset b_shout", int'(b_sh_p), 0);
    rst_n = 1'b1;
    last_en = 1'b1;
    @(posedge clk);

    // Sweep: every operand pair under every sign/direction pair,
    // with per-cycle mode changes, shift-source picks and periodic loads.
    for (int i = 0; i < 1024; i++) begin
      do_op(i & 15, (i >> 4) & 15, (i * 3 + 1) & 15, (i + 5) & 15,
            (i % 5) == 0, (i % 7) == 0,
            ((i >> 8) & 1) ^ (i & 1), ((i >> 9) & 1) ^ ((i >> 1) & 1),
            (i % 37) == 0, 1'b1);
    end

    // Clock enable low: inputs move, nothing may change (R9)
    for (int i = 0; i < 6; i++) begin
      do_op(15 - i, i, i, 15 - i, i[0], i[1], i[0], i[1], i[2], 1'b0);
    end

    // Unsigned borrow and signed corners after a load (R8 R3 R4)
    do_op(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    do_op(3, 3, 0, 0, 0, 0, 0, 1, 0, 1);
    do_op(8, 8, 0, 0, 0, 0, 1, 0, 1, 1);
    for (int i = 0; i < 12; i++) begin
      do_op(8, 8, 0, 0, 0, 0, 1, 0, 0, 1);
    end
    for (int i = 0; i < 12; i++) begin
      do_op(15, 15, 0, 0, 0, 0, 0, 0, 0, 1);
    end
    // Drain the pipeline
    for (int i = 0; i < LAT + 2; i++) begin
      do_op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    end
    @(negedge clk);
    check_outputs();

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule